// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Sequencer

This block walks linked lists of DMA descriptors for two channels, one transmit and one receive, and hands each buffer to an external data mover. Software places descriptors in memory, programs a channel's current pointer, then writes its tail pointer. From then on the channel runs by itself. For each descriptor it fetches the link, buffer address, length and status words over a shared descriptor-memory port, and pulses a start to the data mover. It then waits for the mover's done, marks the descriptor finished in memory, and either follows the link or stops when it has just served the tail.

Each descriptor takes 32 bytes: word 0 holds the link to the next descriptor, word 1 the buffer address, word 2 the byte length and word 3 a status word that software may seed. A small register window gives software the pointers, the fetched fields, a per-channel control word, an interrupt flag and a status word. One engine-wide control word gates channel starts. Both channels share a single memory port that carries one request at a time, and the port alternates between them when both are waiting.

Top module: `sg_desc_chain`

## Requirements
- R1: Register window: the transmit channel occupies byte offsets 0x00-0x1C and the receive channel 0x20-0x3C. Within a channel, word 0 is the next pointer, 1 the buffer address, 2 the length, 3 the current pointer, 4 the tail pointer, 5 control, 6 interrupt flag and 7 status. The engine control word sits at 0x40 and resets to 1. All other registers reset to 0, and accesses with nonzero low address bits are ignored.
- R2: A write to a channel's tail pointer starts that channel only when the channel is idle and bit 0 of the engine control word is 1. With that bit at 0, the channel stays idle and makes no memory request.
- R3: For each descriptor, the channel reads the words at current+0, +4, +8 and +12, in that order. It loads the next-pointer, buffer and length registers, then gives a one-cycle start pulse with the buffer address and length on the data mover outputs.
- R4: The next-pointer register keeps its value from the link fetch until the next descriptor's link fetch.
- R5: A done from the data mover sets status bit 1 (completed) and interrupt flag bit 0. The channel's interrupt output equals that flag ANDed with control bit 0. Status bit 0 reads 1 while the channel is running.
- R6: After done, the channel writes to current+12 the status word it fetched, with bit 28 set and bit 26 set to the end-of-packet input sampled with done. No other descriptor word is written.
- R7: After the write-back, the channel goes idle if the current pointer equals the tail pointer. Otherwise it copies the next pointer into the current pointer and fetches again.
- R8: Writing 1 to interrupt flag bit 0 clears it; writing 0 leaves it set.
- R9: The memory port carries one request at a time and holds its address and direction until acknowledged. When the other channel is waiting at an acknowledge, the port serves that channel next.
- R10: Writes to the current pointer are ignored while the channel is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 7 | Register byte address |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for reg_addr (combinational) |
| mem_req | output | 1 | Descriptor memory request pending |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Descriptor memory byte address |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Request completed (read data valid) |
| mem_rdata | input | DW | Read data |
| tx_start | output | 1 | Transmit buffer start pulse |
| tx_buf_addr | output | AW | Transmit buffer address |
| tx_buf_len | output | LEN_W | Transmit buffer length |
| tx_done | input | 1 | Transmit buffer finished |
| tx_eop | input | 1 | End of packet, sampled with tx_done |
| tx_irq | output | 1 | Transmit interrupt |
| rx_start | output | 1 | Receive buffer start pulse |
| rx_buf_addr | output | AW | Receive buffer address |
| rx_buf_len | output | LEN_W | Receive buffer length |
| rx_done | input | 1 | Receive buffer finished |
| rx_eop | input | 1 | End of packet, sampled with rx_done |
| rx_irq | output | 1 | Receive interrupt |

## Verification
The bench sweeps chain lengths of one to three descriptors on both channels at once, across several memory latencies and data-mover delays. The hard cases are single-descriptor chains, where the halt test must fire on the first write-back, and overlapping traffic on the shared port. A design that tested the tail before the write-back would leave one status word unmarked. A design that followed the link at the tail would issue extra starts and touch memory beyond the chain. A design that lost the other channel's request on hand-over would stall one chain. The sweep also covers a current-pointer write during a run, a disabled engine and a masked interrupt. Misrouting any of these would show up as a wrong pointer, spurious fetches or a wrong interrupt level.

// File: rtl/sg_desc_pkg.sv
package sg_desc_pkg;

   // Channel sequencing states
   typedef enum logic [2:0] {
      CH_IDLE,
      CH_RD_NXT,
      CH_RD_BUF,
      CH_RD_LEN,
      CH_RD_STS,
      CH_XSTART,
      CH_XWAIT,
      CH_WB
   } chan_state_e;

   // Register word index within a channel window
   localparam logic [2:0] RI_NEXT = 3'd0;
   localparam logic [2:0] RI_BUF  = 3'd1;
   localparam logic [2:0] RI_LEN  = 3'd2;
   localparam logic [2:0] RI_CUR  = 3'd3;
   localparam logic [2:0] RI_TAIL = 3'd4;
   localparam logic [2:0] RI_CTRL = 3'd5;
   localparam logic [2:0] RI_IRQ  = 3'd6;
   localparam logic [2:0] RI_STAT = 3'd7;

   // Descriptor word positions
   localparam logic [1:0] DW_LINK   = 2'd0;
   localparam logic [1:0] DW_BUF    = 2'd1;
   localparam logic [1:0] DW_LEN    = 2'd2;
   localparam logic [1:0] DW_STATUS = 2'd3;

   // Write-back flag positions
   localparam int WB_DONE_BIT = 28;
   localparam int WB_EOP_BIT  = 26;

endpackage

// File: rtl/sg_desc_arb.sv
module sg_desc_arb #(
   parameter int N  = 2,
   parameter int AW = 32,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   input  logic [N-1:0]  we,
   input  logic [AW-1:0] addr  [N],
   input  logic [DW-1:0] wdata [N],
   output logic [N-1:0]  ack,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic          mem_ack
);

   localparam int OW = (N > 1) ? $clog2(N) : 1;

   if (N < 2) begin : g_bad_n
      $error("sg_desc_arb needs at least two requesters");
   end

   logic [OW-1:0] owner_q, last_q, pick;
   logic          busy_q, pick_vld;

   // Rotating search starting just after the last served requester
   always_comb begin
      pick_vld = 1'b0;
      pick     = '0;
      for (int k = 1; k <= N; k++) begin
         if (!pick_vld && req[(int'(last_q) + k) % N]) begin
            pick_vld = 1'b1;
            pick     = OW'((int'(last_q) + k) % N);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         owner_q <= '0;
         last_q  <= OW'(N - 1);
      end else if (busy_q) begin
         if (mem_ack) begin
            busy_q <= 1'b0;
            last_q <= owner_q;
         end
      end else if (pick_vld) begin
         busy_q  <= 1'b1;
         owner_q <= pick;
      end
   end

   assign mem_req   = busy_q;
   assign mem_we    = we[owner_q];
   assign mem_addr  = addr[owner_q];
   assign mem_wdata = wdata[owner_q];

   for (genvar i = 0; i < N; i++) begin : g_ack
      assign ack[i] = busy_q && mem_ack && (owner_q == OW'(i));
   end

   // R9: request stays put until acknowledged
   a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // R9: at most one requester sees an acknowledge
   a_r9_single_ack: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ack));

   if (N == 2) begin : g_rr_check
      // R9: a waiting requester is served right after the current one
      a_r9_alternate: assert property (@(posedge clk) disable iff (!rst_n)
         (busy_q && mem_ack && req[!owner_q]) |=> ##1 (busy_q && owner_q != $past(owner_q, 2)));
   end

endmodule

// File: rtl/sg_desc_chan.sv
module sg_desc_chan
   import sg_desc_pkg::*;
#(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   // register access
   input  logic             wr_en,
   input  logic [2:0]       wr_idx,
   input  logic [DW-1:0]    wr_data,
   input  logic [2:0]       rd_idx,
   output logic [DW-1:0]    rd_data,
   input  logic             start_en,
   // descriptor memory
   output logic             mreq,
   output logic             mwe,
   output logic [AW-1:0]    maddr,
   output logic [DW-1:0]    mwdata,
   input  logic             mack,
   input  logic [DW-1:0]    mrdata,
   // data mover
   output logic             dm_start,
   output logic [AW-1:0]    dm_addr,
   output logic [LEN_W-1:0] dm_len,
   input  logic             dm_done,
   input  logic             dm_eop,
   output logic             irq
);

   if (DW <= WB_DONE_BIT) begin : g_bad_dw
      $error("sg_desc_chan data width too narrow for write-back flags");
   end
   if (AW > DW) begin : g_bad_aw
      $error("sg_desc_chan address wider than data word");
   end
   if (LEN_W > DW || LEN_W < 1) begin : g_bad_len
      $error("sg_desc_chan length width out of range");
   end

   chan_state_e     st_q;
   logic [AW-1:0]   cur_q, tail_q, nxt_q, buf_q;
   logic [LEN_W-1:0] len_q;
   logic [DW-1:0]   sts_q, ctrl_q;
   logic            irq_q, done_q, eop_q;
   logic [1:0]      word;
   logic            busy, start_hit;
   logic [DW-1:0]   wb_word, stat_word;

   assign busy      = (st_q != CH_IDLE);
   assign start_hit = wr_en && (wr_idx == RI_TAIL) && start_en && !busy;

   always_comb begin
      case (st_q)
         CH_RD_NXT: word = DW_LINK;
         CH_RD_BUF: word = DW_BUF;
         CH_RD_LEN: word = DW_LEN;
         default:   word = DW_STATUS;
      endcase
   end

   assign mreq   = (st_q == CH_RD_NXT) || (st_q == CH_RD_BUF) || (st_q == CH_RD_LEN)
                || (st_q == CH_RD_STS) || (st_q == CH_WB);
   assign mwe    = (st_q == CH_WB);
   assign maddr  = cur_q + AW'({word, 2'b00});
   assign wb_word = sts_q | (DW'(1) << WB_DONE_BIT) | (DW'(eop_q) << WB_EOP_BIT);
   assign mwdata = wb_word;

   assign dm_start = (st_q == CH_XSTART);
   assign dm_addr  = buf_q;
   assign dm_len   = len_q;
   assign irq      = irq_q & ctrl_q[0];

   always_comb begin
      stat_word    = '0;
      stat_word[0] = busy;
      stat_word[1] = done_q;
   end

   always_comb begin
      case (rd_idx)
         RI_NEXT: rd_data = DW'(nxt_q);
         RI_BUF:  rd_data = DW'(buf_q);
         RI_LEN:  rd_data = DW'(len_q);
         RI_CUR:  rd_data = DW'(cur_q);
         RI_TAIL: rd_data = DW'(tail_q);
         RI_CTRL: rd_data = ctrl_q;
         RI_IRQ:  rd_data = DW'(irq_q);
         default: rd_data = stat_word;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= CH_IDLE;
         cur_q  <= '0;
         tail_q <= '0;
         nxt_q  <= '0;
         buf_q  <= '0;
         len_q  <= '0;
         sts_q  <= '0;
         ctrl_q <= '0;
         irq_q  <= 1'b0;
         done_q <= 1'b0;
         eop_q  <= 1'b0;
      end else begin
         // software side
         if (wr_en) begin
            case (wr_idx)
               RI_CUR:  if (!busy) cur_q <= wr_data[AW-1:0];
               RI_TAIL: tail_q <= wr_data[AW-1:0];
               RI_CTRL: ctrl_q <= wr_data;
               RI_IRQ:  if (wr_data[0]) irq_q <= 1'b0;
               default: ;
            endcase
         end
         // sequencing side (its updates win)
         case (st_q)
            CH_IDLE: begin
               if (start_hit) begin
                  st_q   <= CH_RD_NXT;
                  done_q <= 1'b0;
               end
            end
            CH_RD_NXT: if (mack) begin
               nxt_q <= mrdata[AW-1:0];
               st_q  <= CH_RD_BUF;
            end
            CH_RD_BUF: if (mack) begin
               buf_q <= mrdata[AW-1:0];
               st_q  <= CH_RD_LEN;
            end
            CH_RD_LEN: if (mack) begin
               len_q <= mrdata[LEN_W-1:0];
               st_q  <= CH_RD_STS;
            end
            CH_RD_STS: if (mack) begin
               sts_q <= mrdata;
               st_q  <= CH_XSTART;
            end
            CH_XSTART: st_q <= CH_XWAIT;
            CH_XWAIT: if (dm_done) begin
               eop_q  <= dm_eop;
               done_q <= 1'b1;
               irq_q  <= 1'b1;
               st_q   <= CH_WB;
            end
            CH_WB: if (mack) begin
               if (cur_q == tail_q) begin
                  st_q <= CH_IDLE;
               end else begin
                  cur_q <= nxt_q;
                  st_q  <= CH_RD_NXT;
               end
            end
            default: st_q <= CH_IDLE;
         endcase
      end
   end

   // R4: link value only changes during the link fetch
   a_r4_next_held: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != CH_RD_NXT) |=> $stable(nxt_q));

   // R3: start to the data mover lasts one cycle
   a_r3_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      dm_start |=> !dm_start);

   // R5: done marks completion and raises the flag
   a_r5_done_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == CH_XWAIT && dm_done) |=> (done_q && irq_q));

   // R7: halting after the tail write-back
   a_r7_halt_at_tail: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == CH_WB && mack && cur_q == tail_q) |=> (st_q == CH_IDLE));

   // R7: idle channel is quiet on both sides
   a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == CH_IDLE) |-> (!mreq && !dm_start));

   // R10: current pointer is untouched by software while running
   a_r10_cur_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !(st_q == CH_WB && mack)) |=> $stable(cur_q));

endmodule

// File: rtl/sg_desc_chain.sv
module sg_desc_chain
   import sg_desc_pkg::*;
#(
   parameter int AW       = 32,
   parameter int DW       = 32,
   parameter int LEN_W    = 16,
   parameter int CTRL_RST = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [6:0]       reg_addr,
   input  logic             reg_wen,
   input  logic [DW-1:0]    reg_wdata,
   output logic [DW-1:0]    reg_rdata,
   output logic             mem_req,
   output logic             mem_we,
   output logic [AW-1:0]    mem_addr,
   output logic [DW-1:0]    mem_wdata,
   input  logic             mem_ack,
   input  logic [DW-1:0]    mem_rdata,
   output logic             tx_start,
   output logic [AW-1:0]    tx_buf_addr,
   output logic [LEN_W-1:0] tx_buf_len,
   input  logic             tx_done,
   input  logic             tx_eop,
   output logic             tx_irq,
   output logic             rx_start,
   output logic [AW-1:0]    rx_buf_addr,
   output logic [LEN_W-1:0] rx_buf_len,
   input  logic             rx_done,
   input  logic             rx_eop,
   output logic             rx_irq
);

   localparam int NCH = 2;       // index 0 transmit, 1 receive
   localparam logic [6:0] ENG_CTRL_ADDR = 7'h40;

   logic [DW-1:0]    eng_ctrl_q;
   logic             word_ok;
   logic [NCH-1:0]   dm_start_v, dm_done_v, dm_eop_v, irq_v;
   logic [NCH-1:0]   ch_req, ch_we, ch_ack;
   logic [AW-1:0]    dm_addr_v [NCH];
   logic [LEN_W-1:0] dm_len_v  [NCH];
   logic [AW-1:0]    ch_addr   [NCH];
   logic [DW-1:0]    ch_wdata  [NCH];
   logic [DW-1:0]    ch_rd     [NCH];

   assign word_ok   = (reg_addr[1:0] == 2'b00);
   assign dm_done_v = {rx_done, tx_done};
   assign dm_eop_v  = {rx_eop, tx_eop};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         eng_ctrl_q <= DW'(CTRL_RST);
      end else if (reg_wen && reg_addr == ENG_CTRL_ADDR) begin
         eng_ctrl_q <= reg_wdata;
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (word_ok) begin
         if (reg_addr[6]) begin
            if (reg_addr == ENG_CTRL_ADDR) reg_rdata = eng_ctrl_q;
         end else begin
            reg_rdata = ch_rd[reg_addr[5]];
         end
      end
   end

   for (genvar c = 0; c < NCH; c++) begin : g_chan
      logic sel_wr;
      assign sel_wr = reg_wen && word_ok && !reg_addr[6] && (reg_addr[5] == 1'(c));

      sg_desc_chan #(
         .AW    (AW),
         .DW    (DW),
         .LEN_W (LEN_W)
      ) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (sel_wr),
         .wr_idx   (reg_addr[4:2]),
         .wr_data  (reg_wdata),
         .rd_idx   (reg_addr[4:2]),
         .rd_data  (ch_rd[c]),
         .start_en (eng_ctrl_q[0]),
         .mreq     (ch_req[c]),
         .mwe      (ch_we[c]),
         .maddr    (ch_addr[c]),
         .mwdata   (ch_wdata[c]),
         .mack     (ch_ack[c]),
         .mrdata   (mem_rdata),
         .dm_start (dm_start_v[c]),
         .dm_addr  (dm_addr_v[c]),
         .dm_len   (dm_len_v[c]),
         .dm_done  (dm_done_v[c]),
         .dm_eop   (dm_eop_v[c]),
         .irq      (irq_v[c])
      );
   end

   sg_desc_arb #(
      .N  (NCH),
      .AW (AW),
      .DW (DW)
   ) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (ch_req),
      .we        (ch_we),
      .addr      (ch_addr),
      .wdata     (ch_wdata),
      .ack       (ch_ack),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_ack   (mem_ack)
   );

   assign tx_start    = dm_start_v[0];
   assign tx_buf_addr = dm_addr_v[0];
   assign tx_buf_len  = dm_len_v[0];
   assign tx_irq      = irq_v[0];
   assign rx_start    = dm_start_v[1];
   assign rx_buf_addr = dm_addr_v[1];
   assign rx_buf_len  = dm_len_v[1];
   assign rx_irq      = irq_v[1];

   // R2: with the engine disabled no channel leaves idle on its own
   a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!eng_ctrl_q[0] && !mem_req && !(|ch_req)) |=> !(|ch_req));

endmodule

// File: tb/sg_desc_chain_tb.sv
`timescale 1ns/1ps
module sg_desc_chain_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [6:0]  reg_addr = '0;
   logic        reg_wen = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        tx_start, rx_start, tx_irq, rx_irq;
   logic [31:0] tx_buf_addr, rx_buf_addr;
   logic [15:0] tx_buf_len, rx_buf_len;
   logic [1:0]  done_v = '0;
   logic [1:0]  eop_v  = '0;

   always #2.5 clk = ~clk;

   sg_desc_chain u_dut (
      .clk(clk), .rst_n(rst_n),
      .reg_addr(reg_addr), .reg_wen(reg_wen), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .tx_start(tx_start), .tx_buf_addr(tx_buf_addr), .tx_buf_len(tx_buf_len),
      .tx_done(done_v[0]), .tx_eop(eop_v[0]), .tx_irq(tx_irq),
      .rx_start(rx_start), .rx_buf_addr(rx_buf_addr), .rx_buf_len(rx_buf_len),
      .rx_done(done_v[1]), .rx_eop(eop_v[1]), .rx_irq(rx_irq)
   );

   int n_chk = 0, n_fail = 0;
   logic [31:0] mem [64];
   int lat = 0, dmd = 1, mwait = 0;
   int ncnt [2], seen [2], pcnt [2], mem_acc [2];
   bit pend [2];
   int addr_unstable = 0;
   logic [31:0] held_addr = '0;

   task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] dbase(input int c, input int k);
      return 32'(c * 128 + k * 32);
   endfunction
   function automatic logic [31:0] buf_of(input int c, input int k);
      return 32'h1000 + 32'(c * 256 + k * 16);
   endfunction
   function automatic logic [31:0] len_of(input int c, input int k);
      return 32'(16 + k + 8 * c);
   endfunction
   function automatic logic [31:0] orig_of(input int c, input int k);
      return 32'h100 * 32'(c + 1) + 32'(k);
   endfunction

   // descriptor memory responder
   initial begin
      forever begin
         @(negedge clk);
         if (mem_ack) begin
            mem_ack = 1'b0;
            mwait = 0;
         end else if (mem_req) begin
            if (mwait == 0) held_addr = mem_addr;
            else if (mem_addr != held_addr) addr_unstable++;
            if (mwait >= lat) begin
               mem_ack = 1'b1;
               if (mem_we) mem[mem_addr[7:2]] = mem_wdata;
               else        mem_rdata = mem[mem_addr[7:2]];
               mem_acc[mem_addr[7]]++;
            end else begin
               mwait++;
            end
         end
      end
   end

   // data mover model
   initial begin
      forever begin
         @(negedge clk);
         for (int c = 0; c < 2; c++) begin
            logic st;
            st = (c == 0) ? tx_start : rx_start;
            if (done_v[c]) begin
               done_v[c] = 1'b0;
            end else if (pend[c]) begin
               if (pcnt[c] <= 1) begin
                  done_v[c] = 1'b1;
                  eop_v[c]  = (seen[c] == ncnt[c]);
                  pend[c]   = 1'b0;
               end else begin
                  pcnt[c]--;
               end
            end
            if (st) begin
               // R3: start carries the fetched buffer fields
               check_eq("R3 start within chain", 32'(seen[c] < ncnt[c]), 32'd1);
               check_eq("R3 buffer address", (c == 0) ? tx_buf_addr : rx_buf_addr, buf_of(c, seen[c]));
               check_eq("R3 buffer length", 32'((c == 0) ? tx_buf_len : rx_buf_len), len_of(c, seen[c]));
               seen[c]++;
               pend[c] = 1'b1;
               pcnt[c] = dmd;
            end
         end
      end
   end

   task automatic wr(input logic [6:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
      @(negedge clk);
      reg_wen = 1'b0;
   endtask

   task automatic rd(input logic [6:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      reg_wen = 1'b0;
      done_v = '0; eop_v = '0;
      for (int c = 0; c < 2; c++) begin
         pend[c] = 1'b0; seen[c] = 0; mem_acc[c] = 0; pcnt[c] = 0; ncnt[c] = 0;
      end
      addr_unstable = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic run_case(input int ntx, input int nrx, input int l, input int d,
                           input bit poke, input bit ien);
      logic [31:0] v, v2;
      bit idle;
      lat = l; dmd = d;
      do_reset();
      ncnt[0] = ntx; ncnt[1] = nrx;
      for (int w = 0; w < 64; w++) mem[w] = 32'hDEAD0000 + 32'(w);
      for (int c = 0; c < 2; c++) begin
         for (int k = 0; k < ncnt[c]; k++) begin
            int w;
            w = int'(dbase(c, k)) / 4;
            mem[w]     = (k < ncnt[c] - 1) ? dbase(c, k + 1) : dbase(c, 0);
            mem[w + 1] = buf_of(c, k);
            mem[w + 2] = len_of(c, k);
            mem[w + 3] = orig_of(c, k);
         end
      end
      wr(7'h14, 32'(ien));
      wr(7'h34, 32'(ien));
      wr(7'h0C, dbase(0, 0));
      wr(7'h2C, dbase(1, 0));
      wr(7'h10, dbase(0, ntx - 1));
      if (poke) wr(7'h0C, 32'h0000_0060);   // R10: ignored while running
      wr(7'h30, dbase(1, nrx - 1));
      idle = 1'b0;
      for (int i = 0; i < 3000 && !idle; i++) begin
         rd(7'h1C, v); rd(7'h3C, v2);
         idle = !v[0] && !v2[0] && !pend[0] && !pend[1];
      end
      check_eq("R7 both chains halted", 32'(idle), 32'd1);
      for (int c = 0; c < 2; c++) begin
         logic [6:0] b;
         int last;
         b = (c == 0) ? 7'h00 : 7'h20;
         last = ncnt[c] - 1;
         check_eq("R7 start count", 32'(seen[c]), 32'(ncnt[c]));
         rd(b + 7'h1C, v); check_eq("R5 status completed, not busy", v, 32'h2);
         rd(b + 7'h0C, v); check_eq("R7 R10 current pointer at tail", v, dbase(c, last));
         rd(b + 7'h10, v); check_eq("R1 tail pointer readback", v, dbase(c, last));
         rd(b + 7'h00, v); check_eq("R4 next pointer from last link", v, dbase(c, 0));
         rd(b + 7'h04, v); check_eq("R1 buffer register", v, buf_of(c, last));
         rd(b + 7'h08, v); check_eq("R1 length register", v, len_of(c, last));
         rd(b + 7'h18, v); check_eq("R5 interrupt flag", v, 32'h1);
         check_eq("R5 interrupt output", 32'((c == 0) ? tx_irq : rx_irq), 32'(ien));
         check_eq("R9 memory accesses per channel", 32'(mem_acc[c]), 32'(5 * ncnt[c]));
         for (int k = 0; k < ncnt[c]; k++) begin
            int w;
            w = int'(dbase(c, k)) / 4;
            check_eq("R6 status write-back", mem[w + 3],
                     orig_of(c, k) | 32'h1000_0000 | ((k == last) ? 32'h0400_0000 : 32'h0));
            check_eq("R6 link word untouched", mem[w],
                     (k < last) ? dbase(c, k + 1) : dbase(c, 0));
            check_eq("R6 spare word untouched", mem[w + 4], 32'hDEAD0000 + 32'(w + 4));
         end
         wr(b + 7'h18, 32'h0);
         rd(b + 7'h18, v); check_eq("R8 write 0 keeps flag", v, 32'h1);
         wr(b + 7'h18, 32'h1);
         rd(b + 7'h18, v); check_eq("R8 write 1 clears flag", v, 32'h0);
         check_eq("R8 interrupt output low", 32'((c == 0) ? tx_irq : rx_irq), 32'h0);
      end
      check_eq("R9 address stable while pending", 32'(addr_unstable), 32'd0);
   endtask

   initial begin
      logic [31:0] v;
      do_reset();
      // R1: reset values across the window
      for (int i = 0; i < 16; i++) begin
         rd(7'(i * 4), v);
         check_eq("R1 reset value", v, 32'h0);
      end
      rd(7'h40, v); check_eq("R1 engine control reset", v, 32'h1);
      check_eq("R1 no request after reset", 32'(mem_req), 32'd0);
      // R1: misaligned write ignored
      wr(7'h0D, 32'h55);
      rd(7'h0C, v); check_eq("R1 misaligned write ignored", v, 32'h0);

      // R2: disabled engine does not start
      wr(7'h40, 32'h0);
      rd(7'h40, v); check_eq("R2 engine control readback", v, 32'h0);
      wr(7'h10, 32'h0);
      repeat (20) @(negedge clk);
      rd(7'h1C, v); check_eq("R2 channel stays idle", v, 32'h0);
      check_eq("R2 no memory traffic", 32'(mem_acc[0] + mem_acc[1]), 32'd0);
      check_eq("R2 no start pulse", 32'(seen[0]), 32'd0);

      // near-exhaustive sweep
      for (int nt = 1; nt <= 3; nt++)
         for (int nr = 1; nr <= 3; nr++)
            for (int l = 0; l <= 2; l++)
               for (int d = 1; d <= 3; d += 2)
                  run_case(nt, nr, l, d, 1'b0, 1'b1);

      // R10: current pointer write during a run; R5: masked interrupt
      run_case(3, 2, 1, 2, 1'b1, 1'b1);
      run_case(2, 3, 0, 1, 1'b0, 1'b0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule